// File: doc/BRIEF.md
# Local-Bus Strobe Sequencer

This block produces the control strobes of a 16-bit processor's local bus when the processor drives its bus without an external bus controller. A request names the cycle to run: memory read, memory write, I/O read, I/O write or interrupt acknowledge. The block then steps through the four bus states T1 to T4. It drives a one-shot address-latch strobe, the direction line and the active-low enable of a data transceiver, and a line that selects memory or I/O.

The sequencer runs on a clock at twice the bus-state rate. Each bus state therefore has a first (high) half and a second (low) half, and the boundary between them is the middle of the state. A second bus master can ask for the bus with a synchronous hold request. The grant is only given at the middle of T4 or at the middle of an idle bus state. At that instant the direction, enable and memory/I/O lines are released: their output enables drop and their values rest at logic one. The address-latch strobe is always driven.

Top module: `bus_ctl_seq`

## Requirements
- R1: `ale` is high for exactly one clock in each bus cycle, the second clock after the clock in which `req_ready` is high, which is the low half of T1. It is low at all other times, including while `hlda` is high. It has no output enable.
- R2: A request (`req_valid` with `req_kind`: 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 interrupt acknowledge) is taken in the clock where `req_ready` is high. Eight clocks follow: T1, T2, T3 and T4, each taking two clocks. A request already pending in the last clock of T4 starts the next T1 with no idle clock in between.
- R3: In read and interrupt-acknowledge cycles, `den_n` is low from the low half of T2 through the high half of T4, which is four clocks. That is clocks 4 to 7 of the cycle, counting T1's high half as clock 1.
- R4: In write cycles, `den_n` is low from the high half of T2 through the high half of T4, which is five clocks, clocks 3 to 7.
- R5: Outside those windows, and after reset, `den_n` is high. After reset, `ale`, `hlda` and `req_ready` are low and all output enables are high.
- R6: From T1 onward, `dtr` is 1 for the two write kinds and 0 otherwise, and `mio` is 1 for the memory kinds and 0 otherwise. Interrupt acknowledge gives `dtr`=0 and `mio`=0. Both hold their values until the next T1.
- R7: `hold_req` is sampled on the clock edge. `hlda` rises only in the low half of T4 or of an idle bus state, so a hold asked for during T1 to T3 is granted at the middle of T4 of that cycle.
- R8: In the same clock that `hlda` rises, and as long as it stays high, `dtr_oe`, `den_oe` and `mio_oe` are low and `dtr`, `den_n` and `mio` are 1.
- R9: `hlda` falls in the clock after `hold_req` is sampled low. The output enables stay low until the T1 of the next bus cycle.
- R10: While `hlda` is high, `req_ready` stays low and no bus cycle starts. A pending request starts only after `hlda` has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus-state rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A bus cycle is requested |
| req_kind | input | 3 | Kind of the requested cycle |
| req_ready | output | 1 | Request taken; T1 starts next clock |
| hold_req | input | 1 | Another master asks for the bus |
| hlda | output | 1 | Bus granted to the other master |
| ale | output | 1 | Address-latch strobe |
| dtr | output | 1 | Transceiver direction, 1 = transmit |
| dtr_oe | output | 1 | Output enable of `dtr` |
| den_n | output | 1 | Transceiver enable, active low |
| den_oe | output | 1 | Output enable of `den_n` |
| mio | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| mio_oe | output | 1 | Output enable of `mio` |

## Verification
The bench builds the block with its default parameters: a 3-bit kind code and a rest level of one on released lines. These values make every cycle kind reachable, along with the exact released value that R8 requires. With the two-phase clock, every half of every bus state shows up as its own clock at the ports. The bench therefore checks the strobe windows of each kind clock by clock, the back-to-back start without idle, and a hold request raised mid-cycle that must wait for the middle of T4.

// File: rtl/bus_ctl_pkg.sv
package bus_ctl_pkg;

    localparam int KIND_W  = 3;
    localparam int STATE_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_MEM_RD = 3'd0,
        K_MEM_WR = 3'd1,
        K_IO_RD  = 3'd2,
        K_IO_WR  = 3'd3,
        K_INTA   = 3'd4
    } bus_kind_e;

    typedef enum logic [STATE_W-1:0] {
        S_IDLE = 3'd0,
        S_T1   = 3'd1,
        S_T2   = 3'd2,
        S_T3   = 3'd3,
        S_T4   = 3'd4,
        S_HOLD = 3'd5
    } tstate_e;

    // Line values that a cycle kind selects.
    typedef struct packed {
        logic writes;
        logic memory;
    } kind_lines_t;

    function automatic kind_lines_t kind_lines(input bus_kind_e k);
        kind_lines_t r;
        r.writes = (k == K_MEM_WR) || (k == K_IO_WR);
        r.memory = (k == K_MEM_RD) || (k == K_MEM_WR);
        return r;
    endfunction

    // Transceiver enable window; low_half = second clock of the state.
    function automatic logic den_window(input tstate_e st, input logic low_half,
                                        input logic writes);
        logic on;
        case (st)
            S_T2:    on = writes ? 1'b1 : low_half;
            S_T3:    on = 1'b1;
            S_T4:    on = !low_half;
            default: on = 1'b0;
        endcase
        return on;
    endfunction

endpackage

// File: rtl/bus_tstate_fsm.sv
module bus_tstate_fsm
    import bus_ctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  logic    grant,
    output tstate_e st,
    output logic    low_half,
    output logic    req_ready
);
    tstate_e st_q, st_d;
    logic    ph_q;
    logic    may_start;

    assign may_start = (st_q == S_IDLE || st_q == S_T4) && !grant;
    assign req_ready = ph_q && may_start && req_valid;

    always_comb begin
        st_d = st_q;
        if (ph_q) begin
            case (st_q)
                S_T1:    st_d = S_T2;
                S_T2:    st_d = S_T3;
                S_T3:    st_d = S_T4;
                S_T4,
                S_IDLE:  st_d = grant ? S_HOLD : (req_valid ? S_T1 : S_IDLE);
                S_HOLD:  st_d = grant ? S_HOLD : S_IDLE;
                default: st_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= S_IDLE;
            ph_q <= 1'b0;
        end else begin
            st_q <= st_d;
            ph_q <= !ph_q;
        end
    end

    assign st       = st_q;
    assign low_half = ph_q;
endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb
    import bus_ctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    hold_req,
    input  tstate_e st,
    input  logic    low_half,
    output logic    grant,
    output logic    grant_set
);
    logic g_q;
    logic mid_ok;

    // Edge that ends the first half of T4 or of an idle state.
    assign mid_ok    = !low_half && (st == S_T4 || st == S_IDLE);
    assign grant_set = !g_q && hold_req && mid_ok;

    always_ff @(posedge clk) begin
        if (rst)
            g_q <= 1'b0;
        else if (grant_set)
            g_q <= 1'b1;
        else if (g_q && !hold_req)
            g_q <= 1'b0;
    end

    assign grant = g_q;
endmodule

// File: rtl/bus_strobe_dec.sv
module bus_strobe_dec
    import bus_ctl_pkg::*;
#(
    parameter logic FLOAT_LVL = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  bus_kind_e kind_in,
    input  logic      start,
    input  logic      release_bus,
    input  tstate_e   st,
    input  logic      low_half,
    output logic      ale,
    output logic      dtr,
    output logic      dtr_oe,
    output logic      den_n,
    output logic      den_oe,
    output logic      mio,
    output logic      mio_oe
);
    bus_kind_e   kind_q;
    logic        drive_q;
    kind_lines_t lines;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= K_MEM_RD;
            drive_q <= 1'b1;
        end else begin
            if (start) begin
                kind_q  <= kind_in;
                drive_q <= 1'b1;
            end else if (release_bus) begin
                drive_q <= 1'b0;
            end
        end
    end

    assign lines = kind_lines(kind_q);

    always_comb begin
        ale    = (st == S_T1) && low_half;
        dtr_oe = drive_q;
        den_oe = drive_q;
        mio_oe = drive_q;
        if (drive_q) begin
            dtr   = lines.writes;
            mio   = lines.memory;
            den_n = !den_window(st, low_half, lines.writes);
        end else begin
            dtr   = FLOAT_LVL;
            mio   = FLOAT_LVL;
            den_n = FLOAT_LVL;
        end
    end
endmodule

// File: rtl/bus_ctl_seq.sv
module bus_ctl_seq
    import bus_ctl_pkg::*;
#(
    parameter logic FLOAT_LVL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    output logic              req_ready,
    input  logic              hold_req,
    output logic              hlda,
    output logic              ale,
    output logic              dtr,
    output logic              dtr_oe,
    output logic              den_n,
    output logic              den_oe,
    output logic              mio,
    output logic              mio_oe
);
    tstate_e st_w;
    logic    ph_w;
    logic    grant_w;
    logic    grant_set_w;
    logic    ready_w;

    bus_tstate_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .grant     (grant_w),
        .st        (st_w),
        .low_half  (ph_w),
        .req_ready (ready_w)
    );

    bus_hold_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .hold_req  (hold_req),
        .st        (st_w),
        .low_half  (ph_w),
        .grant     (grant_w),
        .grant_set (grant_set_w)
    );

    bus_strobe_dec #(.FLOAT_LVL(FLOAT_LVL)) u_dec (
        .clk         (clk),
        .rst         (rst),
        .kind_in     (bus_kind_e'(req_kind)),
        .start       (ready_w),
        .release_bus (grant_set_w),
        .st          (st_w),
        .low_half    (ph_w),
        .ale         (ale),
        .dtr         (dtr),
        .dtr_oe      (dtr_oe),
        .den_n       (den_n),
        .den_oe      (den_oe),
        .mio         (mio),
        .mio_oe      (mio_oe)
    );

    assign req_ready = ready_w;
    assign hlda      = grant_w;
endmodule

// File: rtl/bus_ctl_seq_chk.sv
module bus_ctl_seq_chk #(
    parameter logic FLOAT_LVL = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic hold_req,
    input logic hlda,
    input logic ale,
    input logic dtr,
    input logic dtr_oe,
    input logic den_n,
    input logic den_oe,
    input logic mio,
    input logic mio_oe,
    input logic low_half
);
    assert_ale_one_clock_R1: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);
    assert_ale_low_half_R1: assert property (@(posedge clk) disable iff (rst)
        ale |-> low_half);
    assert_ale_after_ready_R2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> ##2 ale);
    assert_den_read_start_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(den_n) && !dtr) |-> low_half);
    assert_den_write_start_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(den_n) && dtr) |-> !low_half);
    assert_den_end_mid_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(den_n) |-> low_half);
    assert_grant_mid_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(hlda) |-> low_half);
    assert_released_R8: assert property (@(posedge clk) disable iff (rst)
        hlda |-> (!dtr_oe && !den_oe && !mio_oe));
    assert_rest_level_R8: assert property (@(posedge clk) disable iff (rst)
        hlda |-> (dtr == FLOAT_LVL && den_n == FLOAT_LVL && mio == FLOAT_LVL));
    assert_drop_grant_R9: assert property (@(posedge clk) disable iff (rst)
        (hlda && !hold_req) |=> !hlda);
    assert_no_start_in_hold_R10: assert property (@(posedge clk) disable iff (rst)
        hlda |-> !req_ready);
endmodule

bind bus_ctl_seq bus_ctl_seq_chk #(.FLOAT_LVL(FLOAT_LVL)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .hold_req  (hold_req),
    .hlda      (hlda),
    .ale       (ale),
    .dtr       (dtr),
    .dtr_oe    (dtr_oe),
    .den_n     (den_n),
    .den_oe    (den_oe),
    .mio       (mio),
    .mio_oe    (mio_oe),
    .low_half  (ph_w)
);

// File: tb/bus_ctl_seq_tb_top.sv
module bus_ctl_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_kind = 3'd0;
    logic       hold_req = 1'b0;
    logic       req_ready, hlda, ale, dtr, dtr_oe, den_n, den_oe, mio, mio_oe;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #5 clk = !clk;

    bus_ctl_seq dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_ready(req_ready), .hold_req(hold_req), .hlda(hlda), .ale(ale),
        .dtr(dtr), .dtr_oe(dtr_oe), .den_n(den_n), .den_oe(den_oe),
        .mio(mio), .mio_oe(mio_oe)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<=20000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests = n_tests + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Runs one bus cycle; hold_at >= 0 raises hold_req after that clock's sample.
    task automatic run_cycle(input logic [2:0] k, input int hold_at, output int waits);
        bit wr, mem, rd_den, grant_now;
        wr  = (k == 3'd1) || (k == 3'd3);
        mem = (k == 3'd0) || (k == 3'd1);
        req_kind  = k;
        req_valid = 1'b1;
        waits = 0;
        #1;
        while (!req_ready && waits < 100) begin
            @(negedge clk);
            #1;
            waits++;
        end
        check("R2 request taken", req_ready, 1'b1);
        for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            if (s == 0) req_valid = 1'b0;
            #1;
            grant_now = (hold_at >= 0) && (hold_at <= 6) && (s == 7);
            check("R1 ale slot", ale, (s == 1));
            check("R7 hlda slot", hlda, grant_now);
            if (grant_now) begin
                check("R8 oe released", {dtr_oe, den_oe, mio_oe}, 3'b000);
                check("R8 rest level", {dtr, den_n, mio}, 3'b111);
            end else begin
                check("R9 oe driven in cycle", {dtr_oe, den_oe, mio_oe}, 3'b111);
                rd_den = wr ? (s >= 2 && s <= 6) : (s >= 3 && s <= 6);
                if (wr) check("R4 den write window", den_n, !rd_den);
                else    check("R3 den read window", den_n, !rd_den);
                check("R6 dtr", dtr, wr);
                check("R6 mio", mio, mem);
            end
            if (s == hold_at) hold_req = 1'b1;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        check("R5 reset den_n", den_n, 1'b1);
        check("R5 reset ale", ale, 1'b0);
        check("R5 reset hlda", hlda, 1'b0);
        check("R5 reset ready", req_ready, 1'b0);
        check("R5 reset oe", {dtr_oe, den_oe, mio_oe}, 3'b111);
    endtask

    task automatic t_all_kinds();
        int w;
        for (int k = 0; k < 5; k++) begin
            run_cycle(3'(k), -1, w);
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                #1;
                check("R5 den idle", den_n, 1'b1);
                check("R1 ale idle", ale, 1'b0);
            end
        end
    endtask

    task automatic t_back_to_back();
        int w;
        run_cycle(3'd1, -1, w);
        run_cycle(3'd2, -1, w);
        check("R2 no idle between cycles", w, 0);
        run_cycle(3'd4, -1, w);
        check("R2 no idle after read", w, 0);
    endtask

    task automatic t_hold_idle();
        int n;
        @(negedge clk);
        hold_req = 1'b1;
        n = 0;
        #1;
        while (!hlda && n < 10) begin
            check("R7 no early float", dtr_oe, 1'b1);
            @(negedge clk);
            #1;
            n++;
        end
        check("R7 grant from idle within 2", (n >= 1 && n <= 2), 1'b1);
        check("R8 float at grant", {dtr_oe, den_oe, mio_oe}, 3'b000);
        check("R8 rest level idle", {dtr, den_n, mio}, 3'b111);
        @(negedge clk);
        hold_req = 1'b0;
        #1;
        check("R8 hlda held", hlda, 1'b1);
        @(negedge clk);
        #1;
        check("R9 hlda fell", hlda, 1'b0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            #1;
            check("R9 still floated", {dtr_oe, den_oe, mio_oe}, 3'b000);
            check("R1 ale no float", ale, 1'b0);
        end
    endtask

    task automatic t_hold_mid_and_wait();
        int w;
        run_cycle(3'd0, 0, w);
        req_kind  = 3'd3;
        req_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            #1;
            check("R10 no start in hold", req_ready, 1'b0);
            check("R10 hlda kept", hlda, 1'b1);
            check("R1 ale low in hold", ale, 1'b0);
        end
        hold_req = 1'b0;
        @(negedge clk);
        #1;
        check("R9 hlda fell mid", hlda, 1'b0);
        check("R9 float until T1", dtr_oe, 1'b0);
        run_cycle(3'd3, -1, w);
        check("R10 waited after release", (w >= 1), 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_all_kinds();
        t_back_to_back();
        t_hold_idle();
        begin : after_idle_hold
            int w;
            run_cycle(3'd0, -1, w);
        end
        t_hold_mid_and_wait();
        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule